// File: doc/BRIEF.md
# Chainable Dual Interval Timer

Two down-counting interval timers share one programmable prescaler. The prescaler divides the system clock and produces the count tick. Software reaches every setting through a small 32-bit register bus with a write strobe and a combinational read port. Each timer can run as a one-shot or as a periodic timer. It raises its interrupt when its count reaches zero and holds it until the count is refilled. Timer 1 can also be chained behind timer 0. In that mode it decrements once per timer 0 expiry, so the pair forms one 64-bit count.

Each timer is a three-state machine. The states are T_IDLE (stopped), T_COUNT (counting down) and T_ZERO (expired, interrupt high). The transitions are:
- **start**: T_IDLE to T_COUNT, one cycle after the run bit is set.
- **expire**: T_COUNT to T_ZERO, on a tick with the count at 1 or 0.
- **reload**: T_ZERO to T_COUNT, on a tick in periodic mode with a nonzero refill value.
- **load**: any running state to T_COUNT, on a software load. The one exception is a zero refill value while in T_ZERO, which stays in T_ZERO.
- **stop**: any state to T_IDLE whenever the run bit is clear.

Register map (word addresses on `bus_addr`):

| Address | Register |
|---|---|
| 0 | Control, timer 0 |
| 1 | Control, timer 1 |
| 2 | Refill value, timer 0 |
| 3 | Refill value, timer 1 |
| 4 | Prescaler divisor |
| 5 | Current count, timer 0 (read only) |
| 6 | Current count, timer 1 (read only) |

Top module: `tmr_pair`

## Requirements
- R1: After reset, all registers read 0, both interrupts are low, and both timers are stopped.
- R2: The prescaler holds a 16-bit divisor P in bits 15:0 of address 4, and bits 31:16 read 0. It issues one tick every P+1 clock cycles. A write to address 4 restarts the division from zero.
- R3: Writing a control word with bit 1 (load) set copies the timer's refill value into its count. The new value is visible one cycle after the write. Bit 1 always reads back 0.
- R4: A timer whose control bit 0 (run) is 1 decrements once per tick. When a tick finds the count at 1 or 0, the count becomes 0, the interrupt goes high and control bit 5 (status, read only) is set.
- R5: With control bit 2 (periodic mode) set, the first tick after expiry refills the count from the refill value and drops the interrupt.
- R6: With bit 2 clear, an expired timer stays at 0 with its interrupt high until a load or a stop.
- R7: A load with a nonzero refill value clears a pending interrupt. A load with a refill value of 0 leaves it high.
- R8: While bit 0 is 0, the interrupt is low, the status bit reads 0 and the count holds its value.
- R9: Control bit 6 (chain) on timer 1 makes it decrement only on the cycles where timer 0 expires. On timer 0, bit 6 is ignored and reads 0.
- R10: Control words read back as run in bit 0, periodic mode in bit 2, status in bit 5 and chain in bit 6, with all other bits 0. Addresses 5 and 6 return the live counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 3 | Word address for both write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq0 | output | 1 | Timer 0 interrupt, high while expired |
| irq1 | output | 1 | Timer 1 interrupt, high while expired |

## Verification
The assertions check, on every cycle, several rules:
- a stopped timer drops its interrupt;
- an asserted interrupt always pairs with a zero count;
- a one-shot timer holds its interrupt;
- a load copies the refill value and, when that value is nonzero, clears the interrupt;
- a chained timer 1 holds its count between timer 0 expiries.

Some properties only the bench scenarios can show, because they need a reference model running alongside the design:
- the exact tick spacing for a given divisor;
- the refill period in periodic mode;
- the 64-bit carry pattern of the chained pair;
- the read-back of every register.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        T_IDLE  = 2'd0,
        T_COUNT = 2'd1,
        T_ZERO  = 2'd2
    } tmr_state_e;

    // word addresses on the register bus
    localparam int unsigned A_CTRL0 = 0;
    localparam int unsigned A_REL0  = 2;
    localparam int unsigned A_PDIV  = 4;
    localparam int unsigned A_CNT0  = 5;

    // control word bit positions
    localparam int unsigned B_RUN  = 0;
    localparam int unsigned B_LOAD = 1;
    localparam int unsigned B_MODE = 2;
    localparam int unsigned B_STAT = 5;
    localparam int unsigned B_CASC = 6;
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] div,
    input  logic             clr,
    output logic             tick
);
    logic [PRE_W-1:0] pcnt_q;

    assign tick = (pcnt_q == div);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             mode,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] rel,
    output logic [CNT_W-1:0] cnt,
    output logic             irq,
    output logic             stat,
    output logic             uflow
);
    tmr_state_e       st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             stat_q, stat_n;

    // next-state and datapath decision
    always_comb begin
        st_n   = st_q;
        cnt_n  = cnt_q;
        stat_n = stat_q;
        uflow  = 1'b0;
        if (!run) begin
            st_n   = T_IDLE;                         // stop
            stat_n = 1'b0;
            if (load) cnt_n = rel;
        end else if (load) begin
            cnt_n = rel;                             // load
            if (rel != '0 || st_q != T_ZERO) st_n = T_COUNT;
        end else begin
            unique case (st_q)
                T_IDLE:  st_n = T_COUNT;             // start
                T_COUNT: begin
                    if (tick) begin
                        if (cnt_q <= CNT_W'(1)) begin
                            cnt_n  = '0;             // expire
                            st_n   = T_ZERO;
                            stat_n = 1'b1;
                            uflow  = 1'b1;
                        end else begin
                            cnt_n = cnt_q - 1'b1;
                        end
                    end
                end
                T_ZERO: begin
                    if (tick && mode) begin
                        cnt_n = rel;                 // reload
                        if (rel != '0) st_n = T_COUNT;
                    end
                end
                default: st_n = T_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= T_IDLE;
            cnt_q  <= '0;
            stat_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            cnt_q  <= cnt_n;
            stat_q <= stat_n;
        end
    end

    // outputs
    always_comb begin
        irq  = (st_q == T_ZERO);
        cnt  = cnt_q;
        stat = stat_q;
    end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq0,
    output logic              irq1
);
    localparam int NT = 2;

    logic [NT-1:0]    run_q, mode_q, casc_q;
    logic [CNT_W-1:0] rel_q [NT];
    logic [PRE_W-1:0] div_q;
    logic [NT-1:0]    wr_ctrl, load_s, irq_s, stat_s, uflow_s, tick_s;
    logic [CNT_W-1:0] cnt_s [NT];
    logic             wr_div, tick;

    assign wr_div = bus_wr && (bus_addr == ADDR_W'(A_PDIV));

    tmr_presc #(.PRE_W(PRE_W)) i_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (div_q),
        .clr  (wr_div),
        .tick (tick)
    );

    for (genvar g = 0; g < NT; g++) begin : g_tmr
        assign wr_ctrl[g] = bus_wr && (bus_addr == ADDR_W'(A_CTRL0 + g));
        assign load_s[g]  = wr_ctrl[g] && bus_wdata[B_LOAD];
        if (g == 0) begin : g_head
            assign tick_s[g] = tick;
        end else begin : g_chain
            assign tick_s[g] = casc_q[g] ? uflow_s[g-1] : tick;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run_q[g]  <= 1'b0;
                mode_q[g] <= 1'b0;
                casc_q[g] <= 1'b0;
                rel_q[g]  <= '0;
            end else begin
                if (wr_ctrl[g]) begin
                    run_q[g]  <= bus_wdata[B_RUN];
                    mode_q[g] <= bus_wdata[B_MODE];
                    casc_q[g] <= (g != 0) && bus_wdata[B_CASC];
                end
                if (bus_wr && bus_addr == ADDR_W'(A_REL0 + g))
                    rel_q[g] <= bus_wdata[CNT_W-1:0];
            end
        end

        tmr_unit #(.CNT_W(CNT_W)) i_unit (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (run_q[g]),
            .mode (mode_q[g]),
            .tick (tick_s[g]),
            .load (load_s[g]),
            .rel  (rel_q[g]),
            .cnt  (cnt_s[g]),
            .irq  (irq_s[g]),
            .stat (stat_s[g]),
            .uflow(uflow_s[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (wr_div) div_q <= bus_wdata[PRE_W-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(0), ADDR_W'(1): begin
                bus_rdata[B_RUN]  = run_q[bus_addr[0]];
                bus_rdata[B_MODE] = mode_q[bus_addr[0]];
                bus_rdata[B_STAT] = stat_s[bus_addr[0]];
                bus_rdata[B_CASC] = casc_q[bus_addr[0]];
            end
            ADDR_W'(2): bus_rdata = 32'(rel_q[0]);
            ADDR_W'(3): bus_rdata = 32'(rel_q[1]);
            ADDR_W'(4): bus_rdata = 32'(div_q);
            ADDR_W'(5): bus_rdata = 32'(cnt_s[0]);
            ADDR_W'(6): bus_rdata = 32'(cnt_s[1]);
            default:    bus_rdata = '0;
        endcase
    end

    assign irq0 = irq_s[0];
    assign irq1 = irq_s[1];
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq0,
    input logic             run0,
    input logic             run1,
    input logic             mode0,
    input logic             casc1,
    input logic             load0,
    input logic             load1,
    input logic             uflow0,
    input logic [CNT_W-1:0] rel0,
    input logic [CNT_W-1:0] cnt0,
    input logic [CNT_W-1:0] cnt1
);
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run0 |=> !irq0);                                           // R8
    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq0 |-> (cnt0 == '0));                                     // R4
    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq0 && run0 && !mode0 && !load0) |=> irq0);               // R6
    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        load0 |=> (cnt0 == $past(rel0)));                           // R3
    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (load0 && rel0 != '0) |=> !irq0);                           // R7
    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run1 && casc1 && !uflow0 && !load1) |=> $stable(cnt1));    // R9
endmodule

bind tmr_pair tmr_pair_chk #(.CNT_W(CNT_W)) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .irq0  (irq0),
    .run0  (run_q[0]),
    .run1  (run_q[1]),
    .mode0 (mode_q[0]),
    .casc1 (casc_q[1]),
    .load0 (load_s[0]),
    .load1 (load_s[1]),
    .uflow0(uflow_s[0]),
    .rel0  (rel_q[0]),
    .cnt0  (cnt_s[0]),
    .cnt1  (cnt_s[1])
);

// File: tb/test_tmr_pair.sv
`timescale 1ns/100ps
module test_tmr_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq0, irq1;

    int    n_chk = 0, n_fail = 0;
    string req = "R1";
    bit    done = 1'b0;

    always #4 clk = ~clk;

    tmr_pair i_tmr_pair (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq0(irq0), .irq1(irq1)
    );

    // behavioural reference: 0 = stopped, 1 = counting, 2 = expired
    int          m_st [2];
    logic [31:0] m_cnt [2], m_rel [2];
    bit          m_stat [2], m_run [2], m_mode [2], m_casc [2];
    logic [15:0] m_div, m_pre;

    always @(posedge clk) begin : model
        bit          tk, uf, tk_k, ld;
        int          nst [2];
        logic [31:0] ncnt [2];
        bit          nstat [2];
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_st[k] = 0; m_cnt[k] = 0; m_rel[k] = 0;
                m_stat[k] = 0; m_run[k] = 0; m_mode[k] = 0; m_casc[k] = 0;
            end
            m_div = 0; m_pre = 0;
        end else begin
            tk = (m_pre == m_div);
            uf = 1'b0;
            for (int k = 0; k < 2; k++) begin
                tk_k = (k == 1 && m_casc[1]) ? uf : tk;
                ld   = bus_wr && bus_addr == 3'(k) && bus_wdata[1];
                nst[k] = m_st[k]; ncnt[k] = m_cnt[k]; nstat[k] = m_stat[k];
                if (!m_run[k]) begin
                    nst[k] = 0; nstat[k] = 0;
                    if (ld) ncnt[k] = m_rel[k];
                end else if (ld) begin
                    ncnt[k] = m_rel[k];
                    if (m_rel[k] != 0 || m_st[k] != 2) nst[k] = 1;
                end else if (m_st[k] == 0) begin
                    nst[k] = 1;
                end else if (m_st[k] == 1 && tk_k) begin
                    if (m_cnt[k] <= 1) begin
                        ncnt[k] = 0; nst[k] = 2; nstat[k] = 1;
                        if (k == 0) uf = 1'b1;
                    end else begin
                        ncnt[k] = m_cnt[k] - 1;
                    end
                end else if (m_st[k] == 2 && tk_k && m_mode[k]) begin
                    ncnt[k] = m_rel[k];
                    if (m_rel[k] != 0) nst[k] = 1;
                end
            end
            for (int k = 0; k < 2; k++) begin
                m_st[k] = nst[k]; m_cnt[k] = ncnt[k]; m_stat[k] = nstat[k];
                if (bus_wr && bus_addr == 3'(k)) begin
                    m_run[k]  = bus_wdata[0];
                    m_mode[k] = bus_wdata[2];
                    m_casc[k] = (k == 1) && bus_wdata[6];
                end
                if (bus_wr && bus_addr == 3'(2 + k)) m_rel[k] = bus_wdata;
            end
            if (bus_wr && bus_addr == 3'd4) begin
                m_div = bus_wdata[15:0]; m_pre = 0;
            end else begin
                m_pre = tk ? 16'd0 : m_pre + 16'd1;
            end
        end
    end

    function automatic logic [31:0] exp_rd(int a);
        case (a)
            0, 1:    return {25'd0, m_casc[a], m_stat[a], 2'd0, m_mode[a], 1'b0, m_run[a]};
            2, 3:    return m_rel[a-2];
            4:       return {16'd0, m_div};
            5, 6:    return m_cnt[a-5];
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one cycle: compare everything, then leave the bus idle
    task automatic cyc();
        @(negedge clk);
        bus_wr = 1'b0;
        check("irq0", 32'(irq0), 32'(m_st[0] == 2));
        check("irq1", 32'(irq1), 32'(m_st[1] == 2));
        for (int a = 0; a < 7; a++) begin
            bus_addr = 3'(a);
            #0.3;
            check($sformatf("read addr %0d", a), bus_rdata, exp_rd(a));
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        cyc();
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        req = "R1"; idle(2);                 // reset state
        req = "R4"; wr(2, 32'd5); wr(0, 32'h3); idle(10);   // one-shot countdown
        req = "R6"; idle(5);                 // stays expired
        req = "R7"; wr(0, 32'h3); idle(2);   // nonzero load clears
        idle(8);
        wr(2, 32'd0); wr(0, 32'h3); idle(3); // zero load keeps irq
        req = "R3"; wr(2, 32'd3); wr(0, 32'h3); idle(2);
        req = "R5"; wr(0, 32'h7); idle(20);  // periodic
        req = "R8"; wr(0, 32'h0); idle(4);   // stop clears irq and status
        req = "R2"; wr(4, 32'hFFFF_0003); wr(2, 32'd4); wr(0, 32'h7); idle(40);
        wr(4, 32'd1); idle(12);
        req = "R9"; wr(4, 32'd0); wr(2, 32'd2); wr(0, 32'h47); // bit 6 ignored on timer 0
        wr(3, 32'd3); wr(1, 32'h47); idle(40);
        req = "R10"; wr(1, 32'h07); idle(10); wr(1, 32'h0); wr(0, 32'h0); idle(3);
        done = 1'b1;
        summary();
    end
endmodule